// File: doc/BRIEF.md
# Grouped Rotating Bus Arbiter

This block is the central arbiter of a shared parallel bus with four masters. Each master has its own active-low request line and its own active-low grant line. The masters are split at build time into a high-rate group and a low-rate group. In rotational mode, each high-rate member gets one turn per round. The low-rate members share one extra turn per round and take that turn in rotation. A fixed-priority mode can be selected instead, in which the lowest-numbered requester always wins.

Arbitration runs in the background while the current owner is still moving data, so no cycles are spent on it. The arbiter never drives the bus itself. It watches the frame and initiator-ready lines, both active-low. A transaction has started when frame is sampled low in the cycle after a cycle in which both lines were high. Only such a start moves the rotation forward, and it is charged to the master that held the grant. When nobody requests, the grant is parked. The parking target is either a fixed master chosen by parameter or the master that last started a transaction.

Top module: `grp_bus_arbiter`

## Requirements
- R1: While reset is applied, every grant output is high. After reset, the first rotational grant goes to the lowest-numbered member of the high-rate group. The first low-rate turn goes to the lowest-numbered low-rate member.
- R2: At most one grant output is low in any cycle.
- R3: A grant never moves directly from one master to another. There is at least one cycle with all grants high between the two owners.
- R4: Rotational mode with the high-rate group {0,1}, the low-rate group {2,3} and all masters requesting: the masters start in the order 0,1,2,0,1,3, and this order repeats.
- R5: A master that is not requesting is skipped, and the other turns keep their order. For example, with masters 1,2,3 requesting the order is 1,2,1,3. A grant held by a non-requesting master while another master requests is withdrawn in the next cycle.
- R6: Rotation state advances only on a transaction start. A start is frame low in a cycle that follows a cycle with frame and initiator-ready both high. A granted master that does not start keeps its grant.
- R7: With rot_mode low, the lowest-numbered requesting master is granted every time.
- R8: A new grant can be asserted while frame of the current transaction is still low.
- R9: With no requests and park_last low, the grant rests on master PARK_ID.
- R10: With no requests and park_last high, the grant rests on the master that last started a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | NM | Per-master request, active low |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| rot_mode | input | 1 | 1 = grouped rotation, 0 = fixed priority |
| park_last | input | 1 | 1 = park on last owner, 0 = park on PARK_ID |
| gnt_n | output | NM | Per-master grant, active low |

## Verification
The bench builds the arbiter with four masters, masters 0 and 1 in the high-rate group, and PARK_ID set to 3. Parking on master 3 can never be mistaken for a reset-time default or for the first rotational winner. Splitting the masters two and two lets the low-rate turn visibly alternate between two masters. The request patterns in the table cover a full load, a load confined to one group, and loads that mix the groups. A long transaction lets the next grant appear while frame is still low.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    PARK_FIXED = 1'b0,
    PARK_LAST  = 1'b1
  } park_mode_e;
endpackage

// File: rtl/rr_pick.sv
// Cyclic first-set search: returns the first set request at or after ptr.
module rr_pick #(
  parameter int W  = 4,
  parameter int PW = 2
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < W; k++) begin
      int pos;
      pos = (int'(ptr) + k) % W;
      if (!any && req[pos]) begin
        any = 1'b1;
        idx = PW'(pos);
      end
    end
  end
endmodule

// File: rtl/bus_watch.sv
// Detects the first cycle of a transaction: frame low after an idle cycle.
module bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start
);
  logic idle_q;
  logic idle_d;

  always_comb idle_d = frame_n & irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b1;
    else        idle_q <= idle_d;
  end

  assign start = idle_q & ~frame_n;
endmodule

// File: rtl/grp_bus_arbiter.sv
module grp_bus_arbiter
  import arb_pkg::*;
#(
  parameter int          NM       = 4,
  parameter logic [NM-1:0] G1_MASK = 4'b0011,
  parameter int          PARK_ID  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          rot_mode,
  input  logic          park_last,
  output logic [NM-1:0] gnt_n
);
  localparam int IW = $clog2(NM);
  localparam int SW = $clog2(NM + 1);
  localparam logic [SW-1:0] G2_SLOT = SW'(NM);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NM-1:0] req;
  assign req = ~req_n;

  // state
  logic [NM-1:0] gnt_q, gnt_d;
  logic [SW-1:0] top_ptr, top_ptr_d;
  logic [IW-1:0] g2_ptr, g2_ptr_d;
  logic [IW-1:0] last_own, last_own_d;

  // transaction start detection
  logic start;
  bus_watch u_watch (
    .clk(clk), .rst_n(rst_s), .frame_n(frame_n), .irdy_n(irdy_n), .start(start)
  );

  // slot ring: high-rate members at their own index, low-rate group at slot NM
  logic [NM:0] slot_req;
  always_comb begin
    for (int i = 0; i < NM; i++) slot_req[i] = req[i] & G1_MASK[i];
    slot_req[NM] = |(req & ~G1_MASK);
  end

  logic          slot_any, g2_any, fix_any;
  logic [SW-1:0] slot_idx;
  logic [IW-1:0] g2_idx, fix_idx;
  logic [IW-1:0] zero_ptr;
  assign zero_ptr = '0;

  rr_pick #(.W(NM + 1), .PW(SW)) u_slot (
    .req(slot_req), .ptr(top_ptr), .any(slot_any), .idx(slot_idx)
  );
  rr_pick #(.W(NM), .PW(IW)) u_g2 (
    .req(req & ~G1_MASK), .ptr(g2_ptr), .any(g2_any), .idx(g2_idx)
  );
  rr_pick #(.W(NM), .PW(IW)) u_fix (
    .req(req), .ptr(zero_ptr), .any(fix_any), .idx(fix_idx)
  );

  // winner and target selection
  park_mode_e    pmode;
  logic          use_g2;
  logic [IW-1:0] winner, target;
  logic [NM-1:0] tgt_oh;

  always_comb begin
    pmode  = park_mode_e'(park_last);
    use_g2 = slot_any && g2_any && (slot_idx == G2_SLOT);
    if (rot_mode) winner = use_g2 ? g2_idx : IW'(slot_idx);
    else          winner = fix_idx;
    if (fix_any)                 target = winner;
    else if (pmode == PARK_LAST) target = last_own;
    else                         target = IW'(PARK_ID);
    tgt_oh = NM'(1) << target;
  end

  // grant hand-off: release first, grant the new owner a cycle later
  always_comb begin
    if (gnt_q == tgt_oh)    gnt_d = gnt_q;
    else if (gnt_q != '0)   gnt_d = '0;
    else                    gnt_d = tgt_oh;
  end

  // owner of the transaction that just started
  logic [IW-1:0] own_idx;
  logic          own_vld, used;
  always_comb begin
    own_idx = '0;
    for (int i = 0; i < NM; i++) if (gnt_q[i]) own_idx = IW'(i);
    own_vld = |gnt_q;
    used    = start & own_vld;
  end

  always_comb begin
    last_own_d = own_idx;
    top_ptr_d  = top_ptr;
    g2_ptr_d   = g2_ptr;
    if (G1_MASK[own_idx]) begin
      top_ptr_d = SW'(own_idx) + SW'(1);
    end else begin
      top_ptr_d = '0;
      g2_ptr_d  = (own_idx == IW'(NM - 1)) ? '0 : own_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      gnt_q    <= '0;
      top_ptr  <= '0;
      g2_ptr   <= '0;
      last_own <= IW'(PARK_ID);
    end else begin
      gnt_q <= gnt_d;
      if (used) begin
        top_ptr  <= top_ptr_d;
        g2_ptr   <= g2_ptr_d;
        last_own <= last_own_d;
      end
    end
  end

  assign gnt_n = ~gnt_q;

  // checks on grant behaviour
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(~gnt_n));

  assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (gnt_q != '0) |=> (gnt_q == '0 || $stable(gnt_q)));

  assert_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ((|req) && gnt_q != '0 && (gnt_q & req) == '0) |=> (gnt_q == '0));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!start) |=> ($stable(top_ptr) && $stable(g2_ptr)));
endmodule

// File: tb/grp_bus_arbiter_bench.sv
`timescale 1ns/1ps
module grp_bus_arbiter_bench;
  localparam int NM   = 4;
  localparam int PARK = 3;
  localparam int NROW = 9;
  localparam int NSEQ = 9;

  // row: {request mask[3:0], rot, owner1 .. owner9 (2 bits each, first at MSB)}
  localparam logic [22:0] TBL [NROW] = '{
    {4'b1111, 1'b1, 2'd0,2'd1,2'd2,2'd0,2'd1,2'd3,2'd0,2'd1,2'd2}, // R4
    {4'b0011, 1'b1, 2'd0,2'd1,2'd0,2'd1,2'd0,2'd1,2'd0,2'd1,2'd0}, // R4
    {4'b0101, 1'b1, 2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0}, // R5
    {4'b1110, 1'b1, 2'd1,2'd2,2'd1,2'd3,2'd1,2'd2,2'd1,2'd3,2'd1}, // R5
    {4'b1100, 1'b1, 2'd2,2'd3,2'd2,2'd3,2'd2,2'd3,2'd2,2'd3,2'd2}, // R5 R1
    {4'b1001, 1'b1, 2'd0,2'd3,2'd0,2'd3,2'd0,2'd3,2'd0,2'd3,2'd0}, // R5
    {4'b1111, 1'b0, 2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0}, // R7
    {4'b1010, 1'b0, 2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1}, // R7
    {4'b1100, 1'b0, 2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2}  // R7
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NM-1:0] req_n;
  logic frame_n, irdy_n, rot_mode, park_last;
  logic [NM-1:0] gnt_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  grp_bus_arbiter #(.NM(NM), .G1_MASK(4'b0011), .PARK_ID(PARK)) u_grp_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .rot_mode(rot_mode), .park_last(park_last), .gnt_n(gnt_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // grant monitor: one-hot and hand-off gap
  logic [NM-1:0] prev_g = '0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ($countones(~gnt_n) > 1) begin
        total++; bad++;
        $display("FAIL R2 actual=%b expected=at most one low", gnt_n);
      end
      if (prev_g != '0 && ~gnt_n != '0 && ~gnt_n != prev_g) begin
        total++; bad++;
        $display("FAIL R3 actual=%b expected=gap after %b", ~gnt_n, prev_g);
      end
    end
    prev_g = ~gnt_n;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_grant(output int g);
    g = -1;
    for (int t = 0; t < 20; t++) begin
      if (gnt_n != '1) begin
        for (int i = 0; i < NM; i++) if (!gnt_n[i]) g = i;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic xfer(input int hold);
    frame_n = 1'b0; irdy_n = 1'b0;
    repeat (hold) @(negedge clk);
    frame_n = 1'b1;
    @(negedge clk);
    irdy_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int g;
    rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    rot_mode = 1'b1; park_last = 1'b0;

    // R1: grants high during reset
    repeat (3) @(negedge clk);
    check("R1 reset grants", int'(gnt_n), 15);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      rot_mode = TBL[r][18];
      req_n = ~TBL[r][22:19];
      do_reset();
      for (int k = 0; k < NSEQ; k++) begin
        wait_grant(g);
        check($sformatf("R4/R5/R7 row%0d step%0d", r, k), g, int'(TBL[r][17 - 2*k -: 2]));
        if (g < 0) break;
        xfer(1);
      end
    end

    // R9: fixed parking
    req_n = '1; rot_mode = 1'b1; park_last = 1'b0;
    do_reset();
    check("R9 park fixed", int'(gnt_n), 15 & ~(1 << PARK));

    // R10: park on last owner
    req_n = 4'b1101;
    repeat (4) @(negedge clk);
    wait_grant(g);
    check("R10 owner before park", g, 1);
    xfer(1);
    req_n = '1; park_last = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 park last", int'(gnt_n), 15 & ~(1 << 1));
    park_last = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 park fixed again", int'(gnt_n), 15 & ~(1 << PARK));

    // R6: granted but never started keeps the grant
    req_n = 4'b1100; rot_mode = 1'b1;
    do_reset();
    repeat (10) @(negedge clk);
    check("R6 no start holds grant", int'(gnt_n), 15 & ~1);

    // R8: hidden arbitration during a long transaction
    frame_n = 1'b0; irdy_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 frame still low", int'(frame_n), 0);
    check("R8 next grant during transfer", int'(gnt_n), 15 & ~(1 << 1));
    frame_n = 1'b1;
    @(negedge clk); irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    wait_grant(g);
    check("R6 one start per transaction a", g, 1);
    xfer(1);
    wait_grant(g);
    check("R6 one start per transaction b", g, 0);

    done = 1'b1;
    finish_run();
  end
endmodule